// File: doc/BRIEF.md
# UART FIFO Flush and Interrupt Control

This block sits between the host and the shift-register side of one UART channel. It contains a transmit queue and a receive queue, plus one byte-wide control register at a single host address. The host loads the transmit queue, and the transmit shift register drains it. The receive shift register fills the receive queue, and the host reads it back out. Each queue has a push/pop handshake, a fill level, and full and empty indications.

The control register holds two write-only flush commands, one per queue. Each flush empties only the queue storage. A byte that a shift register has already popped is outside the queue, so a flush cannot reach it. The register also holds three enable bits. Each one lets one sticky status flag (receive overflow, transmit overflow, receive underflow) reach a single registered host interrupt. The flags come in as inputs, and this block only gates them. The register can be written at any time, including while traffic is flowing.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, the register reads 0x00, the interrupt output is 0, both queues are empty, both levels are 0 and neither queue is full.
- R2: Bits [2:0] of a register write are stored and read back unchanged. Bit 2 enables receive overflow, bit 1 enables transmit overflow and bit 0 enables receive underflow. A write is accepted in any cycle.
- R3: Bits [7:3] always read as 0. Data written to bits [5:3] has no effect on the value read back or on the queues.
- R4: Writing a 1 to bit 7 empties the transmit queue one cycle after the write edge. After that, the level is 0, empty is 1 and full is 0.
- R5: Writing a 1 to bit 6 empties the receive queue one cycle after the write edge. After that, the level is 0 and data-available is 0.
- R6: A flush affects only the queue it names. Writing 0 to a flush bit leaves that queue's contents and level unchanged.
- R7: In the cycle in which a queue is being cleared, a push or pop to that queue is discarded, and the queue ends up empty.
- R8: Each queue returns its data in first-in, first-out order. A push while full is ignored, and a pop while empty is ignored. The head entry is visible on the pop data output whenever the queue is not empty.
- R9: The interrupt output equals the registered OR of (receive overflow AND bit 2), (transmit overflow AND bit 1) and (receive underflow AND bit 0). It appears one clock after the inputs it is computed from, using the enable values held before that clock edge.
- R10: Every write replaces all three enable bits. A write issued only to request a flush therefore also sets the enables to the value carried in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| tx_push | input | 1 | Load one byte into the transmit queue |
| tx_push_data | input | DATA_W | Byte to load into the transmit queue |
| tx_pop | input | 1 | Transmit shift register takes the head byte |
| tx_pop_data | output | DATA_W | Head byte of the transmit queue |
| tx_level | output | clog2(TX_DEPTH+1) | Transmit queue fill level |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_full | output | 1 | Transmit queue is full |
| rx_push | input | 1 | Receive shift register delivers one byte |
| rx_push_data | input | DATA_W | Byte delivered into the receive queue |
| rx_pop | input | 1 | Host takes the head byte |
| rx_pop_data | output | DATA_W | Head byte of the receive queue |
| rx_level | output | clog2(RX_DEPTH+1) | Receive queue fill level |
| rx_avail | output | 1 | Receive queue holds at least one byte |
| rx_full | output | 1 | Receive queue is full |
| flag_rx_ovf | input | 1 | Sticky receive overflow flag |
| flag_tx_ovf | input | 1 | Sticky transmit overflow flag |
| flag_rx_udf | input | 1 | Sticky receive underflow flag |
| irq | output | 1 | Host interrupt request |

## Verification
The hardest case to reach from the ports is a clearing cycle that coincides with a push or pop on the same queue while the queue is full or nearly full. The flush takes effect one edge after the write, so the colliding traffic has to arrive exactly one cycle late.

Directed sequences set up this collision on each queue. The random stimulus then runs in phases that alternate between push-heavy and pop-heavy traffic, with register writes sprinkled throughout, so that flushes land on full, empty and partly filled queues. A bench model that follows the same one-cycle flush timing predicts every level and head byte.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
   localparam int CTL_W       = 8;
   localparam int BIT_TXFLUSH = 7;
   localparam int BIT_RXFLUSH = 6;
   localparam int BIT_EN_ROVF = 2;
   localparam int BIT_EN_TOVF = 1;
   localparam int BIT_EN_RUDF = 0;
   localparam int N_SRC       = 3;

   // interrupt source bundle, order matches enable bit positions [2:0]
   typedef struct packed {
      logic rx_ovf;
      logic tx_ovf;
      logic rx_udf;
   } irq_src_t;
endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [LW-1:0]     level,
   output logic              full,
   output logic              empty
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0) && (DEPTH > 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("ufc_fifo: DEPTH must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ufc_fifo: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LW-1:0]     cnt;
   logic              do_push, do_pop;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         cnt <= cnt + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= push_data;
   end

   assign pop_data = mem[rd_ptr];
   assign level    = cnt;

   a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !full && level == '0));
   a_r7_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && push) |=> empty);
   a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);
   a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !flush) |=> empty);
endmodule

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
   import ufc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output logic [CTL_W-1:0] rd_data,
   output logic             tx_flush,
   output logic             rx_flush,
   output logic [N_SRC-1:0] irq_en
);
   logic [N_SRC-1:0] en_q;
   logic             txf_q, rxf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         txf_q <= 1'b0;
         rxf_q <= 1'b0;
      end else begin
         txf_q <= wr_en && wr_data[BIT_TXFLUSH];
         rxf_q <= wr_en && wr_data[BIT_RXFLUSH];
         if (wr_en) en_q <= wr_data[N_SRC-1:0];
      end
   end

   // flush commands are strobes: never stored, so they read as zero
   always_comb begin
      rd_data              = '0;
      rd_data[N_SRC-1:0]   = en_q;
   end

   assign tx_flush = txf_q;
   assign rx_flush = rxf_q;
   assign irq_en   = en_q;

   a_r2_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(irq_en));
   a_r4_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_TXFLUSH]) |=> tx_flush);
   a_r6_no_write_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!tx_flush && !rx_flush));
   a_r5_rx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_RXFLUSH]) |=> rx_flush);
endmodule

// File: rtl/ufc_irq_gate.sv
module ufc_irq_gate
   import ufc_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  irq_src_t         src,
   input  logic [N_SRC-1:0] en,
   output logic             irq
);
   logic hit;
   assign hit = |(src & en);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq = irq_q;

      a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         ((src & en) == '0) |=> !irq);
      a_r9_enabled_fires: assert property (@(posedge clk) disable iff (!rst_n)
         (src.rx_ovf && en[BIT_EN_ROVF]) |=> irq);
   end else begin : g_comb
      assign irq = hit;
   end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
   import ufc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            reg_wr,
   input  logic [7:0]                      reg_wdata,
   output logic [7:0]                      reg_rdata,
   input  logic                            tx_push,
   input  logic [DATA_W-1:0]               tx_push_data,
   input  logic                            tx_pop,
   output logic [DATA_W-1:0]               tx_pop_data,
   output logic [$clog2(TX_DEPTH+1)-1:0]   tx_level,
   output logic                            tx_empty,
   output logic                            tx_full,
   input  logic                            rx_push,
   input  logic [DATA_W-1:0]               rx_push_data,
   input  logic                            rx_pop,
   output logic [DATA_W-1:0]               rx_pop_data,
   output logic [$clog2(RX_DEPTH+1)-1:0]   rx_level,
   output logic                            rx_avail,
   output logic                            rx_full,
   input  logic                            flag_rx_ovf,
   input  logic                            flag_tx_ovf,
   input  logic                            flag_rx_udf,
   output logic                            irq
);
   if (CTL_W != 8) begin : g_bad_ctl
      $error("uart_fifo_ctl: control register must be one byte");
   end

   logic             tx_flush, rx_flush, rx_empty;
   logic [N_SRC-1:0] irq_en;
   irq_src_t         src;

   ufc_ctrl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_data  (reg_wdata),
      .rd_data  (reg_rdata),
      .tx_flush (tx_flush),
      .rx_flush (rx_flush),
      .irq_en   (irq_en)
   );

   ufc_fifo #(.DATA_W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .push      (tx_push),
      .push_data (tx_push_data),
      .pop       (tx_pop),
      .pop_data  (tx_pop_data),
      .level     (tx_level),
      .full      (tx_full),
      .empty     (tx_empty)
   );

   ufc_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_flush),
      .push      (rx_push),
      .push_data (rx_push_data),
      .pop       (rx_pop),
      .pop_data  (rx_pop_data),
      .level     (rx_level),
      .full      (rx_full),
      .empty     (rx_empty)
   );

   assign rx_avail = !rx_empty;

   assign src.rx_ovf = flag_rx_ovf;
   assign src.tx_ovf = flag_tx_ovf;
   assign src.rx_udf = flag_rx_udf;

   ufc_irq_gate #(.REG_OUT(1'b1)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .en    (irq_en),
      .irq   (irq)
   );

   a_r6_rx_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flush && !rx_flush && !rx_push && !rx_pop) |=> $stable(rx_level));
   a_r6_tx_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flush && !tx_flush && !tx_push && !tx_pop) |=> $stable(tx_level));
   a_r3_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[7:6] == 2'b00) |=> (reg_rdata[7:3] == 5'b0));
endmodule

// File: tb/tb_uart_fifo_ctl.sv
module tb_uart_fifo_ctl;
   localparam int DW = 8;
   localparam int TD = 8;
   localparam int RD = 8;
   localparam int TLW = $clog2(TD + 1);
   localparam int RLW = $clog2(RD + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [DW-1:0] tx_push_data = '0, rx_push_data = '0;
   logic [DW-1:0] tx_pop_data, rx_pop_data;
   logic [TLW-1:0] tx_level;
   logic [RLW-1:0] rx_level;
   logic tx_empty, tx_full, rx_avail, rx_full, irq;
   logic flag_rx_ovf = 1'b0, flag_tx_ovf = 1'b0, flag_rx_udf = 1'b0;

   always #4 clk = ~clk;

   uart_fifo_ctl #(.DATA_W(DW), .TX_DEPTH(TD), .RX_DEPTH(RD)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .tx_push(tx_push), .tx_push_data(tx_push_data),
      .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_level(tx_level),
      .tx_empty(tx_empty), .tx_full(tx_full), .rx_push(rx_push),
      .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
      .rx_level(rx_level), .rx_avail(rx_avail), .rx_full(rx_full),
      .flag_rx_ovf(flag_rx_ovf), .flag_tx_ovf(flag_tx_ovf),
      .flag_rx_udf(flag_rx_udf), .irq(irq)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model
   logic [DW-1:0] mtx[$];
   logic [DW-1:0] mrx[$];
   logic [2:0] men = '0;
   bit mtxf = 0, mrxf = 0, mirq = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rdata();
      return {5'b0, men};
   endfunction

   function automatic bit exp_irq_next(input logic [2:0] fl);
      return |(fl & men);
   endfunction

   task automatic check_all();
      chk(int'(tx_level) == mtx.size(), "R8 tx level", tx_level, mtx.size());
      chk(tx_empty == (mtx.size() == 0), "R8 tx empty", tx_empty, mtx.size() == 0);
      chk(tx_full == (mtx.size() == TD), "R8 tx full", tx_full, mtx.size() == TD);
      if (mtx.size() != 0)
         chk(tx_pop_data == mtx[0], "R8 tx head", tx_pop_data, mtx[0]);
      chk(int'(rx_level) == mrx.size(), "R8 rx level", rx_level, mrx.size());
      chk(rx_avail == (mrx.size() != 0), "R8 rx avail", rx_avail, mrx.size() != 0);
      chk(rx_full == (mrx.size() == RD), "R8 rx full", rx_full, mrx.size() == RD);
      if (mrx.size() != 0)
         chk(rx_pop_data == mrx[0], "R8 rx head", rx_pop_data, mrx[0]);
      chk(reg_rdata == exp_rdata(), "R3 readback", reg_rdata, exp_rdata());
      chk(irq == mirq, "R9 irq", irq, mirq);
   endtask

   // called at a negedge: drive inputs for one edge, advance model, check at next negedge
   task automatic step(input bit wr, input logic [7:0] wd,
                       input bit tpu, input logic [7:0] td, input bit tpo,
                       input bit rpu, input logic [7:0] rdv, input bit rpo,
                       input logic [2:0] fl);
      bit tfull, temp, rfull, remp;
      reg_wr = wr; reg_wdata = wd;
      tx_push = tpu; tx_push_data = td; tx_pop = tpo;
      rx_push = rpu; rx_push_data = rdv; rx_pop = rpo;
      {flag_rx_ovf, flag_tx_ovf, flag_rx_udf} = fl;
      mirq = exp_irq_next(fl);
      tfull = (mtx.size() == TD); temp = (mtx.size() == 0);
      rfull = (mrx.size() == RD); remp = (mrx.size() == 0);
      if (mtxf) mtx.delete();
      else begin
         if (tpo && !temp) void'(mtx.pop_front());
         if (tpu && !tfull) mtx.push_back(td);
      end
      if (mrxf) mrx.delete();
      else begin
         if (rpo && !remp) void'(mrx.pop_front());
         if (rpu && !rfull) mrx.push_back(rdv);
      end
      mtxf = wr && wd[7];
      mrxf = wr && wd[6];
      if (wr) men = wd[2:0];
      @(negedge clk);
      check_all();
   endtask

   task automatic idle();
      step(0, 8'h00, 0, 8'h00, 0, 0, 8'h00, 0, 3'b000);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      chk(tx_empty && !tx_full && tx_level == 0, "R1 tx empty", tx_level, 0);
      chk(!rx_avail && !rx_full && rx_level == 0, "R1 rx empty", rx_level, 0);

      // R2 enables write/readback
      step(1, 8'h05, 0, 0, 0, 0, 0, 0, 3'b000);
      chk(reg_rdata == 8'h05, "R2 enables", reg_rdata, 5);
      // R3 reserved bits ignored
      step(1, 8'h3A, 0, 0, 0, 0, 0, 0, 3'b000);
      chk(reg_rdata == 8'h02, "R3 reserved", reg_rdata, 2);

      // load both queues
      for (int i = 0; i < 5; i++) step(0, 0, 1, 8'(8'h10 + i), 0, 1, 8'(8'hA0 + i), 0, 3'b000);
      // R6: writing 0 to flush bits leaves data
      step(1, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000);
      idle();
      chk(tx_level == 5 && rx_level == 5, "R6 zero write keeps", tx_level, 5);
      // R4 tx flush, R6 rx kept, R10 enables replaced
      step(1, 8'h81, 0, 0, 0, 0, 0, 0, 3'b000);
      chk(tx_level == 5, "R4 flush not before next edge", tx_level, 5);
      idle();
      chk(tx_empty && !tx_full && tx_level == 0, "R4 tx flushed", tx_level, 0);
      chk(rx_level == 5, "R6 rx untouched", rx_level, 5);
      chk(reg_rdata == 8'h01, "R10 enables replaced", reg_rdata, 1);
      chk(reg_rdata[7:6] == 2'b00, "R3 flush reads zero", reg_rdata[7:6], 0);

      // R7 rx flush colliding with push and pop
      step(1, 8'h40, 0, 0, 0, 0, 0, 0, 3'b000);
      step(0, 0, 1, 8'h55, 0, 1, 8'h66, 1, 3'b000);
      chk(!rx_avail && rx_level == 0, "R7 rx flush wins", rx_level, 0);
      chk(tx_level == 1, "R6 tx push kept", tx_level, 1);
      chk(!rx_avail, "R5 rx avail clear", rx_avail, 0);

      // R8 fill tx to full, push ignored
      for (int i = 0; i < TD + 2; i++) step(0, 0, 1, 8'(8'hC0 + i), 0, 0, 0, 0, 3'b000);
      chk(tx_full && tx_level == TD, "R8 tx full", tx_level, TD);
      // R7 tx flush at full with push and pop in clearing cycle
      step(1, 8'h80, 0, 0, 0, 0, 0, 0, 3'b000);
      step(0, 0, 1, 8'h77, 1, 0, 0, 0, 3'b000);
      chk(tx_empty && tx_level == 0, "R7 tx flush wins", tx_level, 0);

      // R9 interrupt gating
      step(1, 8'h04, 0, 0, 0, 0, 0, 0, 3'b100);
      chk(irq == 1'b0, "R9 old enable used", irq, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 3'b100);
      chk(irq == 1'b1, "R9 rx ovf fires", irq, 1);
      step(0, 0, 0, 0, 0, 0, 0, 0, 3'b011);
      chk(irq == 1'b0, "R9 masked sources", irq, 0);
      step(1, 8'h03, 0, 0, 0, 0, 0, 0, 3'b001);
      step(0, 0, 0, 0, 0, 0, 0, 0, 3'b001);
      chk(irq == 1'b1, "R9 rx udf fires", irq, 1);

      // random phases
      for (int i = 0; i < 6000; i++) begin
         int ph;
         int pp, po;
         logic [7:0] wd;
         ph = (i / 400) % 4;
         pp = (ph == 0) ? 80 : (ph == 1) ? 25 : 50;
         po = (ph == 0) ? 20 : (ph == 1) ? 75 : 50;
         wd = 8'($urandom);
         if (($urandom % 8) != 0) wd[7:6] = 2'b00;
         step(($urandom % 12) == 0, wd,
              ($urandom % 100) < pp, 8'($urandom), ($urandom % 100) < po,
              ($urandom % 100) < pp, 8'($urandom), ($urandom % 100) < po,
              3'($urandom));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule